// File: doc/BRIEF.md
# Test-Pattern Checking Parallel Link Receiver

This block terminates a parallel data bus from a neighbouring trigger system that delivers one word per bunch crossing. Each received word first has a configurable per-line polarity correction applied. The correction repairs lines that a reversed connector has inverted, so no later logic ever sees raw polarity. The block stays idle until a crossing-zero marker arrives alongside a word. From that word on, every crossing's corrected word is stored in a show-ahead capture FIFO, so the stream can be read out at leisure.

While capturing, the block can also verify a walking-ones or walking-zeros test stream, with its count restarted at the marker. Every mismatching line raises a sticky bit in an error mask and adds to a saturating error counter. A separate sticky mask flags lines that never took both values within one full walking cycle. A line that toggles at the wrong time therefore shows up only in the error mask, while a dead line shows up in both masks. A soft clear returns the capture, the checker and the overflow flag to their idle state.

Top module: `link_rx_check`

## Requirements
- R1: Every stored word equals `rx_word XOR cfg_invert`, taken in the same cycle.
- R2: After reset or soft clear, no word is stored or checked until a cycle with `rx_bc0` high, and `rd_valid` stays 0.
- R3: Starting with the marker word, the word of every following cycle is stored in arrival order. `rd_data` shows the oldest stored word whenever `rd_valid` is 1, and `rd_en` removes it at the next edge.
- R4: A word that arrives while the FIFO holds `FIFO_DEPTH` words is dropped and raises `overflow`. The flag then stays high, and no further word is stored until a soft clear, even after the FIFO is drained.
- R5: `soft_clr` empties the FIFO and clears `overflow`, `err_count`, `err_mask`, `stuck_mask` and the marker sequence. It has priority over a word in the same cycle.
- R6: With `cfg_mode` = 1 (walking ones), the word with index n after the marker (the marker word has n = 0) must equal `1 << (n mod W_DATA)`. Each differing line sets its bit in `err_mask`, and the bit stays set.
- R7: With `cfg_mode` = 2 (walking zeros), the expected word is the bitwise complement of the walking-ones value.
- R8: In a checking mode, `err_count` grows by the number of differing lines in each word and saturates at its all-ones value.
- R9: In a checking mode, on the word with n mod W_DATA = W_DATA-1, each line that has not been both 0 and 1 since the word with index 0 sets its sticky `stuck_mask` bit. A line that toggles at the wrong time does not set it. At no other time does `stuck_mask` change.
- R10: With `cfg_mode` = 0 or 3 (passthrough), words are captured but `err_count`, `err_mask` and `stuck_mask` do not change.
- R11: A marker that arrives during capture restarts the index at n = 0 with that word.
- R12: After reset the FIFO is empty, and `overflow`, `err_count`, `err_mask` and `stuck_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of capture, checker and flags |
| rx_word | input | W_DATA | Raw received bus |
| rx_bc0 | input | 1 | Crossing-zero marker for the current word |
| cfg_invert | input | W_DATA | Per-line polarity inversion mask |
| cfg_mode | input | 2 | 0/3 passthrough, 1 walking ones, 2 walking zeros |
| rd_en | input | 1 | Pop the oldest stored word |
| rd_data | output | W_DATA | Oldest stored word |
| rd_valid | output | 1 | FIFO not empty |
| overflow | output | 1 | Sticky: a word was lost to a full FIFO |
| err_count | output | CNT_W | Saturating count of mismatched lines |
| err_mask | output | W_DATA | Sticky per-line mismatch flags |
| stuck_mask | output | W_DATA | Sticky per-line no-toggle flags |

## Verification
The assertions take for granted that `cfg_mode` and `cfg_invert` are held steady through a test sequence. They also assume `soft_clr` never shares a cycle with a marker the bench wants captured. The stimulus changes the configuration only in the cycle that asserts `soft_clr`, and it drives the marker only on clean cycles. The assertions further assume that the FIFO can only be pushed when it is not full, a condition the capture control must guarantee. The stimulus deliberately stops reading in order to reach that boundary.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;
    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,
        MODE_WALK1 = 2'd1,
        MODE_WALK0 = 2'd2,
        MODE_RSVD  = 2'd3
    } chk_mode_e;
endpackage

// File: rtl/link_rx_fifo.sv
module link_rx_fifo #(
    parameter int W     = 26,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic push, pop;

    always_comb begin
        st_d = st_q;
        push = wr_en && (st_q.count != CW'(DEPTH));
        pop  = rd_en && (st_q.count != '0);
        if (push) st_d.wr_ptr = (st_q.wr_ptr == AW'(DEPTH - 1)) ? '0 : st_q.wr_ptr + 1'b1;
        if (pop)  st_d.rd_ptr = (st_q.rd_ptr == AW'(DEPTH - 1)) ? '0 : st_q.rd_ptr + 1'b1;
        st_d.count = st_q.count + CW'(push) - CW'(pop);
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wr_ptr] <= wr_data;
    end

    assign rd_data  = mem[st_q.rd_ptr];
    assign rd_valid = (st_q.count != '0);
    assign full     = (st_q.count == CW'(DEPTH));

    // R4: capture control must never push into a full store
    a_r4_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R3: occupancy never exceeds the storage depth
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));
endmodule

// File: rtl/link_rx_seq.sv
module link_rx_seq #(
    parameter int W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bc0,
    output logic              word_vld,
    output logic [$clog2(W)-1:0] idx
);
    localparam int IW = $clog2(W);

    typedef struct packed {
        logic          active;
        logic [IW-1:0] pos;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        word_vld = bc0 || st_q.active;
        idx      = bc0 ? '0 : st_q.pos;
        st_d.active = st_q.active || bc0;
        if (word_vld) st_d.pos = (idx == IW'(W - 1)) ? '0 : idx + 1'b1;
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a marker always restarts the index, so the next word is index 1
    a_r11_marker_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (bc0 && !clr) |=> (st_q.pos == IW'(1)));
    // R2: once started, capture stays on until a clear
    a_r2_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !clr) |=> st_q.active);
endmodule

// File: rtl/link_rx_pattern.sv
module link_rx_pattern
    import link_rx_pkg::*;
#(
    parameter int W     = 26,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 word_vld,
    input  logic [$clog2(W)-1:0] idx,
    input  chk_mode_e            mode,
    input  logic [W-1:0]         word,
    output logic [W-1:0]         err_mask,
    output logic [CNT_W-1:0]     err_count,
    output logic [W-1:0]         stuck_mask
);
    localparam int IW = $clog2(W);
    localparam int PW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]     mask;
        logic [CNT_W-1:0] count;
        logic [W-1:0]     stuck;
        logic [W-1:0]     seen0;
        logic [W-1:0]     seen1;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic [W-1:0]   expect_w, mism, base0, base1;
    logic [PW-1:0]  n_bad;
    logic [CNT_W:0] sum;
    logic           checking;

    function automatic logic [PW-1:0] ones(input logic [W-1:0] v);
        logic [PW-1:0] c = '0;
        for (int i = 0; i < W; i++) c = c + PW'(v[i]);
        return c;
    endfunction

    always_comb begin
        st_d     = st_q;
        checking = word_vld && (mode == MODE_WALK1 || mode == MODE_WALK0);
        expect_w = W'(1) << idx;
        if (mode == MODE_WALK0) expect_w = ~expect_w;
        mism  = checking ? (word ^ expect_w) : '0;
        n_bad = ones(mism);
        sum   = {1'b0, st_q.count} + (CNT_W + 1)'(n_bad);
        if (checking) begin
            st_d.mask  = st_q.mask | mism;
            st_d.count = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
            base0 = (idx == '0) ? '0 : st_q.seen0;
            base1 = (idx == '0) ? '0 : st_q.seen1;
            st_d.seen0 = base0 | ~word;
            st_d.seen1 = base1 | word;
            if (idx == IW'(W - 1))
                st_d.stuck = st_q.stuck | ~(st_d.seen0 & st_d.seen1);
        end else begin
            base0 = st_q.seen0;
            base1 = st_q.seen1;
        end
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_mask   = st_q.mask;
    assign err_count  = st_q.count;
    assign stuck_mask = st_q.stuck;

    // R6: error mask bits never fall without a clear
    a_r6_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st_q.mask & $past(st_q.mask)) == $past(st_q.mask)));
    // R8: the counter never decreases without a clear
    a_r8_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (st_q.count >= $past(st_q.count)));
    // R10: passthrough leaves the checker results untouched
    a_r10_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && mode != MODE_WALK1 && mode != MODE_WALK0) |=>
        (st_q.count == $past(st_q.count) && st_q.stuck == $past(st_q.stuck)));
    // R9: stuck flags change only on the last word of a cycle
    a_r9_stuck_at_cycle_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(word_vld && idx == IW'(W - 1))) |=> $stable(st_q.stuck));
endmodule

// File: rtl/link_rx_check.sv
module link_rx_check
    import link_rx_pkg::*;
#(
    parameter int W_DATA     = 26,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic [W_DATA-1:0] rx_word,
    input  logic              rx_bc0,
    input  logic [W_DATA-1:0] cfg_invert,
    input  logic [1:0]        cfg_mode,
    input  logic              rd_en,
    output logic [W_DATA-1:0] rd_data,
    output logic              rd_valid,
    output logic              overflow,
    output logic [CNT_W-1:0]  err_count,
    output logic [W_DATA-1:0] err_mask,
    output logic [W_DATA-1:0] stuck_mask
);
    localparam int IW = $clog2(W_DATA);

    typedef struct packed {
        logic ovf;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [W_DATA-1:0] fixed_w;
    logic              word_vld, fifo_full, wr_req, fifo_wr;
    logic [IW-1:0]     idx;

    assign fixed_w = rx_word ^ cfg_invert;

    link_rx_seq #(.W(W_DATA)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .bc0(rx_bc0),
        .word_vld(word_vld), .idx(idx)
    );

    always_comb begin
        st_d    = st_q;
        wr_req  = word_vld && !st_q.ovf;
        fifo_wr = wr_req && !fifo_full && !soft_clr;
        if (wr_req && fifo_full) st_d.ovf = 1'b1;
        if (soft_clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    link_rx_fifo #(.W(W_DATA), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .wr_en(fifo_wr), .wr_data(fixed_w),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .full(fifo_full)
    );

    link_rx_pattern #(.W(W_DATA), .CNT_W(CNT_W)) u_pat (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .word_vld(word_vld), .idx(idx), .mode(chk_mode_e'(cfg_mode)),
        .word(fixed_w),
        .err_mask(err_mask), .err_count(err_count), .stuck_mask(stuck_mask)
    );

    assign overflow = st_q.ovf;

    // R4: overflow holds until a soft clear
    a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !soft_clr) |=> st_q.ovf);
    // R4: nothing is stored once overflow is flagged
    a_r4_no_store_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |-> !fifo_wr);
    // R5: a soft clear leaves an empty, error-free block
    a_r5_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!overflow && !rd_valid && err_count == '0 && stuck_mask == '0));
endmodule

// File: tb/test_link_rx_check.sv
`timescale 1ns/1ps
module test_link_rx_check;
    localparam int W  = 26;
    localparam int DP = 16;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_clr = 1'b0;
    logic [W-1:0]  rx_word = '0;
    logic          rx_bc0 = 1'b0;
    logic [W-1:0]  cfg_invert = '0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          rd_en = 1'b0;
    logic [W-1:0]  rd_data;
    logic          rd_valid, overflow;
    logic [CW-1:0] err_count;
    logic [W-1:0]  err_mask, stuck_mask;

    int n_chk = 0, n_fail = 0;
    bit done = 0, hold = 0;
    logic [W-1:0] exp_q[$];

    logic [CW-1:0] s_cnt;
    logic [W-1:0]  s_mask, s_stuck;
    logic          s_ovf, s_valid;

    always #2 clk = ~clk;

    link_rx_check #(.W_DATA(W), .FIFO_DEPTH(DP), .CNT_W(CW)) i_link_rx_check (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .rx_word(rx_word),
        .rx_bc0(rx_bc0), .cfg_invert(cfg_invert), .cfg_mode(cfg_mode),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .overflow(overflow), .err_count(err_count), .err_mask(err_mask),
        .stuck_mask(stuck_mask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] walk(input int n);
        return W'(1) << (n % W);
    endfunction

    task automatic snap();
        s_cnt = err_count; s_mask = err_mask; s_stuck = stuck_mask;
        s_ovf = overflow; s_valid = rd_valid;
    endtask

    // driver: sample state of previous word, then drive a raw word
    task automatic send(input logic [W-1:0] raw, input logic bc0, input bit store);
        @(negedge clk);
        snap();
        rx_word = raw;
        rx_bc0  = bc0;
        if (store) exp_q.push_back(raw ^ cfg_invert);
    endtask

    task automatic stop_seq();
        @(negedge clk);
        snap();
        rx_bc0 = 1'b0;
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
    endtask

    // monitor: compares FIFO head with scoreboard and pops it
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid && !hold) begin
                if (exp_q.size() == 0) chk("R3 unexpected word", 64'(rd_data), 64'hDEAD);
                else chk("R1/R3 stored word", 64'(rd_data), 64'(exp_q.pop_front()));
                rd_en = 1'b1;
            end else begin
                rd_en = 1'b0;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [W-1:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 rd_valid", 64'(rd_valid), 0);
        chk("R12 overflow", 64'(overflow), 0);
        chk("R12 err_count", 64'(err_count), 0);
        chk("R12 masks", 64'({err_mask, stuck_mask}), 0);

        // R2: words before any marker are ignored
        cfg_mode = 2'd1;
        send(26'h1234567, 0, 0);
        send(26'h0FF00FF, 0, 0);
        send(26'h3FFFFFF, 0, 0);
        stop_seq();
        chk("R2 nothing stored", 64'(s_valid), 0);
        chk("R2 nothing checked", 64'(s_cnt), 0);

        // R1, R3, R10: passthrough with inversion
        cfg_mode = 2'd0; cfg_invert = 26'h2A50F3;
        send(26'h0000001, 1, 1);
        for (int i = 0; i < 10; i++) send(W'(32'h9E3779B1 * (i + 3)), 0, 1);
        cfg_mode = 2'd3;
        send(26'h3FFFFFF, 0, 1);
        stop_seq();
        chk("R10 passthrough count", 64'(s_cnt), 0);
        chk("R10 passthrough stuck", 64'(s_stuck), 0);

        // R6: clean walking ones through the inversion, two cycles
        cfg_mode = 2'd1; cfg_invert = 26'h0000005;
        for (int n = 0; n < 2 * W; n++) send(walk(n) ^ cfg_invert, n == 0, 1);
        stop_seq();
        chk("R6 clean count", 64'(s_cnt), 0);
        chk("R6 clean mask", 64'(s_mask), 0);
        chk("R9 clean stuck", 64'(s_stuck), 0);

        // R6/R8/R9: lines 3 and 4 swapped
        cfg_invert = '0;
        for (int n = 0; n < W; n++) begin
            w = walk(n);
            w = {w[W-1:5], w[3], w[4], w[2:0]};
            send(w, n == 0, 1);
        end
        stop_seq();
        chk("R8 swap count", 64'(s_cnt), 4);
        chk("R6 swap mask", 64'(s_mask), 64'(26'h18));
        chk("R9 swap not stuck", 64'(s_stuck), 0);

        // R9: line 7 dead at 0
        for (int n = 0; n < W; n++) begin
            send(walk(n) & ~W'(26'h80), n == 0, 1);
            if (n == 0) chk("R5 count cleared", 64'(s_cnt), 0);
            if (n == W - 1) chk("R9 stuck not before cycle end", 64'(s_stuck), 0);
        end
        stop_seq();
        chk("R9 stuck line 7", 64'(s_stuck), 64'(26'h80));
        chk("R6 dead mask", 64'(s_mask), 64'(26'h80));
        chk("R8 dead count", 64'(s_cnt), 1);

        // R7: walking zeros, line 2 held at 1
        cfg_mode = 2'd2;
        for (int n = 0; n < W; n++) send(~walk(n) | W'(26'h4), n == 0, 1);
        stop_seq();
        chk("R7 zeros mask", 64'(s_mask), 64'(26'h4));
        chk("R7 zeros stuck", 64'(s_stuck), 64'(26'h4));
        chk("R7 zeros count", 64'(s_cnt), 1);

        // R11: marker mid-cycle restarts the index
        cfg_mode = 2'd1;
        for (int n = 0; n < 5; n++) send(walk(n), n == 0, 1);
        for (int n = 0; n < 4; n++) send(walk(n), n == 0, 1);
        stop_seq();
        chk("R11 restart clean", 64'(s_cnt), 0);

        // R8: saturation with walking zeros and all-zero words
        cfg_mode = 2'd2;
        send('0, 1, 1);
        send('0, 0, 1);
        chk("R8 per-line count", 64'(s_cnt), 25);
        send('0, 0, 1);
        stop_seq();
        chk("R8 saturates", 64'(s_cnt), 63);

        // R4: overflow with reads held off
        cfg_mode = 2'd0; hold = 1;
        for (int n = 0; n < DP; n++) send(W'(n * 3 + 1), n == 0, 1);
        send(26'h3AAAAAA, 0, 0);
        send(26'h1555555, 0, 0);
        chk("R4 overflow set", 64'(s_ovf), 1);
        hold = 0;
        for (int n = 0; n < 24; n++) send(W'(n), 0, 0);
        chk("R4 drained, nothing new", 64'(s_valid), 0);
        chk("R4 overflow held", 64'(s_ovf), 1);
        stop_seq();
        @(negedge clk);
        chk("R5 overflow cleared", 64'(overflow), 0);
        // R5: sequence cleared, words need a new marker
        send(26'h0000123, 0, 0);
        send(26'h0000456, 0, 0);
        stop_seq();
        chk("R5 no capture without marker", 64'(s_valid), 0);
        repeat (3) @(negedge clk);
        chk("R3 scoreboard empty", 64'(exp_q.size()), 0);

        done = 1;
        summary();
    end
endmodule